// File: doc/BRIEF.md
# Streaming Destination Address Match CAM

This block filters received frames by destination address. It keeps a table of 48-bit station addresses. Each entry has its own valid flag. The receive path delivers the address one byte per clock. The block gathers the six bytes into a compare key and reports a single match result one clock after the last byte. A later stage uses that result to keep or drop the frame. Frame delineation and the final keep or drop decision stay outside this block.

A processor changes the table only through four 16-bit registers: three data registers and one command register. It starts a write, read or compare by clearing a go bit in the command register. It then polls that bit until it reads back as one.

The table has a single port, so only one operation can use it in any clock. The receive compare owns its clock outright. A processor operation that falls on the same clock waits one clock. Entries may change while frames are being received, and a receive compare sees every write that finished before its clock.

Top module: `addr_filter_cam`

## Requirements
- R1: After reset, no entry is valid, `match_vld` is 0, the three data registers read 0, and the command register reads 16'hE000.
- R2: A byte with `rx_vld` and `rx_start` both high is placed in key bits 47:40. The next five `rx_vld` bytes fill bits 39:32, 31:24, 23:16, 15:8 and 7:0 in that order. Bytes with `rx_start` low are ignored before the first start byte and after the sixth byte.
- R3: `match_vld` is high for exactly one clock, in the cycle after the first rising edge that follows the edge accepting the sixth byte. In that cycle `match_hit` is 1 exactly when a valid entry equals the key.
- R4: An entry whose valid flag is 0 never produces a hit, whatever address it holds.
- R5: Register map on `cpu_addr`: 0 holds address bits 47:32, 1 holds bits 31:16, 2 holds bits 15:0, and 3 is the command register. Command bits are: 15 read go, 14 write go, 13 compare go, 12 valid flag, 11 compare hit, 5:0 entry index. All other bits read 0. `cpu_rdata` shows the selected register combinationally.
- R6: Clearing bit 14 writes the data-register address into the indexed entry and sets that entry's valid flag from bit 12. Bit 14 then reads back 1.
- R7: Clearing bit 15 loads the indexed entry's address into the data registers and its valid flag into bit 12. Bit 15 then reads back 1.
- R8: Clearing bit 13 compares the data-register address against all valid entries. Bit 11 is set to the hit result, and on a hit the index field takes the lowest matching index. Bit 13 then reads back 1.
- R9: A pending processor operation executes on the first clock edge after the command write, unless the cycle before that edge is a receive compare cycle; in that case it executes one edge later. Receive results are never delayed. When several go bits are clear, they execute one per clock, write first, then read, then compare.
- R10: A table write that executes at or before the edge accepting the sixth byte is seen by that address's compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_vld | input | 1 | Received byte present this cycle |
| rx_start | input | 1 | Marks the first destination address byte |
| rx_byte | input | 8 | Received byte |
| match_vld | output | 1 | One-cycle strobe carrying the address result |
| match_hit | output | 1 | Address matched a valid entry |
| cpu_wr | input | 1 | Processor register write strobe |
| cpu_addr | input | 2 | Processor register select |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Selected register contents |

## Verification
If the sixth byte is accepted at edge E, the receive result appears after edge E+1. A processor command written at edge W completes after edge W+1, or after W+2 when it collides with a receive compare cycle. A behavioural model in the bench advances on every rising edge with the same timing and is compared with the outputs 3 ns after each edge. Directed checks run at falling edges on the exact cycles derived above. These cover a command written together with the sixth byte, and a write landing one edge before the sixth byte.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int unsigned CMD_RD_BIT  = 15;
  localparam int unsigned CMD_WR_BIT  = 14;
  localparam int unsigned CMD_CMP_BIT = 13;
  localparam int unsigned CMD_VLD_BIT = 12;
  localparam int unsigned CMD_HIT_BIT = 11;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2,
    OP_CMP  = 2'd3
  } cam_op_e;
endpackage

// File: rtl/cam_rx_shift.sv
module cam_rx_shift #(
  parameter int ADDR_W = 48,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic              byte_start,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [ADDR_W-1:0] key,
  output logic              cmp_slot
);
  localparam int NBYTES = ADDR_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] key_q, key_n;
  logic              slot_q, slot_n;
  logic              key_en;

  always_comb begin
    cnt_n  = cnt_q;
    key_n  = key_q;
    slot_n = 1'b0;
    key_en = 1'b0;
    if (byte_vld) begin
      if (byte_start) begin
        key_n[ADDR_W-1 -: BYTE_W] = byte_in;
        cnt_n  = CNT_W'(1);
        key_en = 1'b1;
      end else if (cnt_q != '0 && int'(cnt_q) < NBYTES) begin
        key_n[ADDR_W-1-int'(cnt_q)*BYTE_W -: BYTE_W] = byte_in;
        cnt_n  = cnt_q + 1'b1;
        key_en = 1'b1;
        slot_n = (int'(cnt_q) == NBYTES - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      slot_q <= slot_n;
    end
  end

  always_ff @(posedge clk) begin
    if (key_en) key_q <= key_n;
  end

  assign key      = key_q;
  assign cmp_slot = slot_q;
endmodule

// File: rtl/cam_array.sv
module cam_array #(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 48,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_vld,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_vld,
  input  logic [ADDR_W-1:0] cmp_key,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [ADDR_W-1:0]  mem_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] hit_vec;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[idx] <= wr_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q      <= '0;
    else if (wr_en) vld_q[idx] <= wr_vld;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (mem_q[g] == cmp_key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit     = |hit_vec;
  assign rd_addr = mem_q[idx];
  assign rd_vld  = vld_q[idx];
endmodule

// File: rtl/cam_cpu_regs.sv
module cam_cpu_regs
  import cam_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int REG_W  = 16,
  parameter int IDX_W  = 6,
  parameter int CPU_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  logic              rx_slot,
  output logic              arr_wr_en,
  output logic [IDX_W-1:0]  arr_idx,
  output logic [ADDR_W-1:0] cpu_key,
  output logic              arr_wr_vld,
  input  logic [ADDR_W-1:0] arr_rd_addr,
  input  logic              arr_rd_vld,
  input  logic              cmp_hit,
  input  logic [IDX_W-1:0]  cmp_idx
);
  localparam int NREGS = ADDR_W / REG_W;

  logic [REG_W-1:0] dat_q [NREGS];
  logic [REG_W-1:0] dat_n [NREGS];
  logic rd_go_q, wr_go_q, cmp_go_q, flag_q, hit_q;
  logic rd_go_n, wr_go_n, cmp_go_n, flag_n, hit_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [REG_W-1:0] cmd_word;
  logic             cmd_sel;
  cam_op_e          op;

  for (genvar g = 0; g < NREGS; g++) begin : g_key
    assign cpu_key[ADDR_W-1-g*REG_W -: REG_W] = dat_q[g];
  end

  assign cmd_sel = (cpu_addr == CPU_AW'(NREGS));

  always_comb begin
    op = OP_NONE;
    if (!rx_slot) begin
      if (!wr_go_q)       op = OP_WR;
      else if (!rd_go_q)  op = OP_RD;
      else if (!cmp_go_q) op = OP_CMP;
    end
  end

  always_comb begin
    dat_n    = dat_q;
    rd_go_n  = rd_go_q;
    wr_go_n  = wr_go_q;
    cmp_go_n = cmp_go_q;
    flag_n   = flag_q;
    hit_n    = hit_q;
    idx_n    = idx_q;
    case (op)
      OP_WR: wr_go_n = 1'b1;
      OP_RD: begin
        rd_go_n = 1'b1;
        flag_n  = arr_rd_vld;
        for (int g = 0; g < NREGS; g++) dat_n[g] = arr_rd_addr[ADDR_W-1-g*REG_W -: REG_W];
      end
      OP_CMP: begin
        cmp_go_n = 1'b1;
        hit_n    = cmp_hit;
        if (cmp_hit) idx_n = cmp_idx;
      end
      default: ;
    endcase
    if (cpu_wr) begin
      if (cmd_sel) begin
        rd_go_n  = cpu_wdata[CMD_RD_BIT];
        wr_go_n  = cpu_wdata[CMD_WR_BIT];
        cmp_go_n = cpu_wdata[CMD_CMP_BIT];
        flag_n   = cpu_wdata[CMD_VLD_BIT];
        hit_n    = cpu_wdata[CMD_HIT_BIT];
        idx_n    = cpu_wdata[IDX_W-1:0];
      end
      for (int g = 0; g < NREGS; g++) begin
        if (cpu_addr == CPU_AW'(g)) dat_n[g] = cpu_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NREGS; g++) dat_q[g] <= '0;
      rd_go_q  <= 1'b1;
      wr_go_q  <= 1'b1;
      cmp_go_q <= 1'b1;
      flag_q   <= 1'b0;
      hit_q    <= 1'b0;
      idx_q    <= '0;
    end else begin
      dat_q    <= dat_n;
      rd_go_q  <= rd_go_n;
      wr_go_q  <= wr_go_n;
      cmp_go_q <= cmp_go_n;
      flag_q   <= flag_n;
      hit_q    <= hit_n;
      idx_q    <= idx_n;
    end
  end

  always_comb begin
    cmd_word              = '0;
    cmd_word[CMD_RD_BIT]  = rd_go_q;
    cmd_word[CMD_WR_BIT]  = wr_go_q;
    cmd_word[CMD_CMP_BIT] = cmp_go_q;
    cmd_word[CMD_VLD_BIT] = flag_q;
    cmd_word[CMD_HIT_BIT] = hit_q;
    cmd_word[IDX_W-1:0]   = idx_q;
    cpu_rdata             = cmd_sel ? cmd_word : '0;
    for (int g = 0; g < NREGS; g++) begin
      if (cpu_addr == CPU_AW'(g)) cpu_rdata = dat_q[g];
    end
  end

  assign arr_wr_en  = (op == OP_WR);
  assign arr_idx    = idx_q;
  assign arr_wr_vld = flag_q;
endmodule

// File: rtl/addr_filter_cam.sv
module addr_filter_cam #(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 48,
  parameter int BYTE_W  = 8,
  parameter int REG_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_vld,
  input  logic              rx_start,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              match_vld,
  output logic              match_hit,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic [ADDR_W-1:0] rx_key, cpu_key, cmp_key, rd_addr;
  logic              rx_slot, arr_wr_en, wr_vld, rd_vld, hit;
  logic [IDX_W-1:0]  arr_idx, hit_idx;
  logic              mvld_q, mhit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  cam_rx_shift #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_i_n), .byte_vld(rx_vld), .byte_start(rx_start),
    .byte_in(rx_byte), .key(rx_key), .cmp_slot(rx_slot)
  );

  assign cmp_key = rx_slot ? rx_key : cpu_key;

  cam_array #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_arr (
    .clk(clk), .rst_n(rst_i_n), .wr_en(arr_wr_en), .idx(arr_idx),
    .wr_addr(cpu_key), .wr_vld(wr_vld), .rd_addr(rd_addr), .rd_vld(rd_vld),
    .cmp_key(cmp_key), .hit(hit), .hit_idx(hit_idx)
  );

  cam_cpu_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W), .IDX_W(IDX_W), .CPU_AW(2)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rx_slot(rx_slot),
    .arr_wr_en(arr_wr_en), .arr_idx(arr_idx), .cpu_key(cpu_key),
    .arr_wr_vld(wr_vld), .arr_rd_addr(rd_addr), .arr_rd_vld(rd_vld),
    .cmp_hit(hit), .cmp_idx(hit_idx)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mvld_q <= 1'b0;
      mhit_q <= 1'b0;
    end else begin
      mvld_q <= rx_slot;
      mhit_q <= rx_slot & hit;
    end
  end

  assign match_vld = mvld_q;
  assign match_hit = mhit_q;
endmodule

// File: rtl/cam_chk.sv
module cam_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_slot,
  input logic match_vld,
  input logic match_hit,
  input logic arr_wr_en
);
  // R3: the result follows the compare cycle by one clock
  a_r3_result_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rx_slot |=> match_vld);
  // R3: no result strobe without a compare cycle before it
  a_r3_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
    match_vld |-> $past(rx_slot));
  // R3: the strobe is a single-cycle pulse
  a_r3_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    match_vld |=> !match_vld);
  // R3: a hit is only reported together with the strobe
  a_r3_hit_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> match_vld);
  // R9: the receive compare cycle never shares the table with a write
  a_r9_rx_owns_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rx_slot |-> !arr_wr_en);
  // R2: a new compare needs six fresh bytes
  a_r2_slot_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_slot |=> !rx_slot);
endmodule

bind addr_filter_cam cam_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_slot(rx_slot), .match_vld(match_vld),
  .match_hit(match_hit), .arr_wr_en(arr_wr_en)
);

// File: tb/sim_addr_filter_cam.sv
module sim_addr_filter_cam;
  logic        clk, rst_n;
  logic        rx_vld, rx_start;
  logic [7:0]  rx_byte;
  logic        match_vld, match_hit;
  logic        cpu_wr;
  logic [1:0]  cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  addr_filter_cam u0 (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_start(rx_start),
    .rx_byte(rx_byte), .match_vld(match_vld), .match_hit(match_hit),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [47:0] m_mem [64];
  bit          m_val [64];
  logic [15:0] m_d [3];
  logic [15:0] m_cmd;
  logic [47:0] m_key;
  int          m_cnt;
  bit          m_slot, m_mvld, m_mhit;

  function automatic bit m_any(input logic [47:0] k);
    for (int e = 0; e < 64; e++) if (m_val[e] && m_mem[e] == k) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < 64; e++) m_val[e] = 1'b0;
      for (int r = 0; r < 3; r++) m_d[r] = 16'h0;
      m_cmd = 16'hE000; m_cnt = 0; m_slot = 0; m_mvld = 0; m_mhit = 0;
    end else begin
      logic [47:0] dkey;
      int ix;
      bit nslot;
      dkey   = {m_d[0], m_d[1], m_d[2]};
      ix     = int'(m_cmd[5:0]);
      m_mvld = m_slot;
      m_mhit = m_slot && m_any(m_key);
      if (!m_slot) begin
        if (!m_cmd[14]) begin
          m_mem[ix] = dkey; m_val[ix] = m_cmd[12]; m_cmd[14] = 1'b1;
        end else if (!m_cmd[15]) begin
          m_d[0] = m_mem[ix][47:32]; m_d[1] = m_mem[ix][31:16]; m_d[2] = m_mem[ix][15:0];
          m_cmd[12] = m_val[ix]; m_cmd[15] = 1'b1;
        end else if (!m_cmd[13]) begin
          m_cmd[11] = 1'b0;
          for (int e = 63; e >= 0; e--) begin
            if (m_val[e] && m_mem[e] == dkey) begin m_cmd[11] = 1'b1; m_cmd[5:0] = 6'(e); end
          end
          m_cmd[13] = 1'b1;
        end
      end
      nslot = 0;
      if (rx_vld) begin
        if (rx_start) begin
          m_key[47:40] = rx_byte; m_cnt = 1;
        end else if (m_cnt > 0 && m_cnt < 6) begin
          m_key[47-8*m_cnt -: 8] = rx_byte; m_cnt++;
          nslot = (m_cnt == 6);
        end
      end
      m_slot = nslot;
      if (cpu_wr) begin
        if (cpu_addr == 2'd3) m_cmd = cpu_wdata & 16'hF83F;
        else m_d[cpu_addr] = cpu_wdata;
      end
    end
  end

  // per-clock comparison, 3 ns after the rising edge
  always begin
    @(posedge clk);
    #3;
    if (rst_n && !done) begin
      chk(match_vld == m_mvld, "R3 match_vld", 64'(match_vld), 64'(m_mvld));
      chk(match_hit == m_mhit, "R3 match_hit", 64'(match_hit), 64'(m_mhit));
      chk(cpu_rdata == (cpu_addr == 2'd3 ? m_cmd : m_d[cpu_addr]), "R5 rdata",
          64'(cpu_rdata), 64'(cpu_addr == 2'd3 ? m_cmd : m_d[cpu_addr]));
    end
  end

  task automatic cpu_write(input logic [1:0] a, input logic [15:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [15:0] d);
    cpu_addr = a;
    #1;
    d = cpu_rdata;
  endtask

  task automatic load_data(input logic [47:0] a);
    cpu_write(2'd0, a[47:32]);
    cpu_write(2'd1, a[31:16]);
    cpu_write(2'd2, a[15:0]);
  endtask

  // command write at edge W, completion visible after edge W+1
  task automatic run_cmd(input logic [15:0] c);
    cpu_write(2'd3, c);
    @(negedge clk);
  endtask

  task automatic send_addr(input logic [47:0] a);
    for (int i = 0; i < 6; i++) begin
      rx_vld = 1'b1; rx_start = (i == 0); rx_byte = a[47-8*i -: 8];
      @(negedge clk);
    end
    rx_vld = 1'b0; rx_start = 1'b0;
  endtask

  task automatic send_check(input logic [47:0] a, input bit exp, input string req);
    send_addr(a);
    @(negedge clk);
    chk(match_vld == 1'b1 && match_hit == exp, req, {62'h0, match_vld, match_hit},
        {62'h0, 1'b1, exp});
  endtask

  localparam logic [47:0] ADR_A = 48'h0A1B_2C3D_4E5F;
  localparam logic [47:0] ADR_B = 48'h0200_0000_0077;
  localparam logic [47:0] ADR_C = 48'hFFEE_DDCC_BBAA;
  localparam logic [47:0] ADR_D = 48'h1357_9BDF_2468;

  initial begin
    logic [15:0] v;
    int pulses;
    rst_n = 1'b0; rx_vld = 0; rx_start = 0; rx_byte = 0;
    cpu_wr = 0; cpu_addr = 2'd3; cpu_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    cpu_read(2'd3, v); chk(v == 16'hE000, "R1 cmd", 64'(v), 64'hE000);
    cpu_read(2'd0, v); chk(v == 16'h0, "R1 data0", 64'(v), 64'h0);
    chk(match_vld == 1'b0, "R1 match_vld", 64'(match_vld), 64'h0);
    send_check(ADR_A, 1'b0, "R1 empty table");

    load_data(ADR_A);
    run_cmd(16'hB005);
    cpu_read(2'd3, v); chk(v == 16'hF005, "R6 write done", 64'(v), 64'hF005);
    send_check(ADR_A, 1'b1, "R3 hit");
    send_check(ADR_A ^ 48'h1, 1'b0, "R3 miss last byte");
    send_check(ADR_A ^ 48'h0100_0000_0000, 1'b0, "R2 first byte order");

    pulses = 0;
    send_addr(ADR_A);
    for (int i = 0; i < 4; i++) begin
      rx_vld = 1'b1; rx_byte = 8'h0A;
      @(negedge clk);
      if (match_vld) pulses++;
    end
    rx_vld = 1'b0;
    repeat (2) begin @(negedge clk); if (match_vld) pulses++; end
    chk(pulses == 1, "R2 extra bytes ignored", 64'(pulses), 64'd1);

    load_data(48'h0);
    run_cmd(16'h6005);
    cpu_read(2'd0, v); chk(v == 16'h0A1B, "R7 read hi", 64'(v), 64'h0A1B);
    cpu_read(2'd1, v); chk(v == 16'h2C3D, "R7 read mid", 64'(v), 64'h2C3D);
    cpu_read(2'd2, v); chk(v == 16'h4E5F, "R7 read lo", 64'(v), 64'h4E5F);
    cpu_read(2'd3, v); chk(v == 16'hF005, "R7 valid flag", 64'(v), 64'hF005);

    run_cmd(16'hA005);
    send_check(ADR_A, 1'b0, "R4 invalid entry");

    load_data(ADR_B);
    run_cmd(16'hB014);
    run_cmd(16'hB009);
    run_cmd(16'hC000);
    cpu_read(2'd3, v); chk(v == 16'hE809, "R8 compare hit lowest", 64'(v), 64'hE809);
    cpu_write(2'd2, 16'h0078);
    run_cmd(16'hC000);
    cpu_read(2'd3, v); chk(v == 16'hE000, "R8 compare miss", 64'(v), 64'hE000);

    load_data(ADR_C);
    cpu_addr = 2'd3;
    for (int i = 0; i < 6; i++) begin
      rx_vld = 1'b1; rx_start = (i == 0); rx_byte = ADR_C[47-8*i -: 8];
      if (i == 5) begin cpu_wr = 1'b1; cpu_wdata = 16'hB021; end
      @(negedge clk);
    end
    cpu_wr = 1'b0; rx_vld = 1'b0; rx_start = 1'b0;
    @(negedge clk);
    chk(match_vld == 1'b1 && match_hit == 1'b0, "R9 rx not delayed",
        {62'h0, match_vld, match_hit}, 64'h2);
    cpu_read(2'd3, v); chk(v == 16'hB021, "R9 write deferred", 64'(v), 64'hB021);
    @(negedge clk);
    cpu_read(2'd3, v); chk(v == 16'hF021, "R9 write after slot", 64'(v), 64'hF021);

    load_data(ADR_D);
    cpu_addr = 2'd3;
    for (int i = 0; i < 6; i++) begin
      rx_vld = 1'b1; rx_start = (i == 0); rx_byte = ADR_D[47-8*i -: 8];
      if (i == 4) begin cpu_wr = 1'b1; cpu_wdata = 16'hB028; end
      else cpu_wr = 1'b0;
      @(negedge clk);
    end
    cpu_wr = 1'b0; rx_vld = 1'b0; rx_start = 1'b0;
    @(negedge clk);
    chk(match_vld == 1'b1 && match_hit == 1'b1, "R10 live update seen",
        {62'h0, match_vld, match_hit}, 64'h3);

    run_cmd(16'h1005);
    cpu_read(2'd3, v); chk(v == 16'h5005, "R9 write first", 64'(v), 64'h5005);
    @(negedge clk);
    cpu_read(2'd3, v); chk(v == 16'hD005, "R9 read second", 64'(v), 64'hD005);
    @(negedge clk);
    cpu_read(2'd3, v); chk(v == 16'hF805, "R9 compare third", 64'(v), 64'hF805);
    send_check(ADR_D, 1'b1, "R10 entry present");

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule